// File: doc/BRIEF.md
# Triggered Compare-and-Clear Unit

This unit sits beside an external pulse counter. It samples the counter value at trigger instants and tests it against a 16-bit top value. Each accepted trigger produces a one-cycle clear strobe for the counter. The result of the test is captured on a registered match output. The counter itself lives outside the unit.

A trigger has one of two sources. The first is a slow clock tick strobe, divided by 1, 2, 4 or 8. The second is a rising edge on one of six event lines, chosen by a channel select. A polarity bit can invert the chosen line before edge detection. The same chosen line, again after polarity, can also drive a gate output that enables or blocks counting.

The test relation has three forms: count at or below top, count at or above top, or a window. In the window form the upper byte of top is the inclusive upper bound and the lower byte is the inclusive lower bound.

Top module: `tcc_unit`

## Requirements
- R1: While `rst` is high and on the first edge after it, `clr_pulse`, `match_out` and `gate_out` are all 0.
- R2: With `trig_mode` = 1, a trigger fires on every 2^`presc_sel`-th tick, counting ticks since the divider last restarted. Each trigger gives `clr_pulse` = 1 on the next clock edge.
- R3: The tick divider restarts from zero in any cycle where `trig_mode` or `presc_sel` differs from its value one cycle earlier. A tick in that cycle is not counted. The divider also stays at zero whenever `trig_mode` is not 1.
- R4: With `trig_mode` = 2, a trigger fires in the cycle where the chosen line (XOR `ch_invert`) is 1 and was 0 in the previous cycle.
- R5: `cmp_sel` = 0: on a trigger, `match_out` becomes 1 exactly when `cnt_val` <= `top_val`.
- R6: `cmp_sel` = 1: on a trigger, `match_out` becomes 1 exactly when `cnt_val` >= `top_val`.
- R7: `cmp_sel` = 2: on a trigger, `match_out` becomes 1 exactly when `top_val[7:0]` <= `cnt_val` <= `top_val[15:8]`. Both bounds are zero-extended.
- R8: `clr_pulse` is high for exactly the one cycle after each trigger. `match_out` keeps its value between triggers while the configuration stays valid.
- R9: The configuration is invalid when `trig_mode` is 0 or 3, when `cmp_sel` is 3, or when `trig_mode` is 2 and `ch_sel` is 6 or 7. While it is invalid, the next edge gives `clr_pulse` = 0 and `match_out` = 0.
- R10: `gate_out` follows the chosen line after polarity, with one cycle of latency, when `gate_en` = 1. It reads 0 for a channel select of 6 or 7. It is 1 when `gate_en` = 0.
- R11: Event lines that are not selected have no effect on `clr_pulse`, `match_out` or `gate_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Current counter value |
| top_val | input | 16 | Top value or window bounds |
| tick | input | 1 | Slow clock tick strobe |
| evt_ch | input | 6 | Event channel lines |
| trig_mode | input | 2 | 0 off, 1 tick, 2 event edge, 3 reserved |
| presc_sel | input | 2 | Tick division code (divide by 2^code) |
| cmp_sel | input | 2 | 0 <=, 1 >=, 2 window, 3 reserved |
| ch_sel | input | 3 | Event channel index 0..5 |
| ch_invert | input | 1 | Invert chosen line |
| gate_en | input | 1 | Drive gate from chosen line |
| clr_pulse | output | 1 | One-cycle counter clear strobe |
| match_out | output | 1 | Registered compare result |
| gate_out | output | 1 | Count enable gate |

## Verification
Tick triggers are tried at every division code, with sparse and dense tick patterns. The code is also changed in the middle of a count, which separates a divider that restarts from one that carries on. For each relation, counts are swept across the top value and both window bounds. Equal, one-below and one-above values show whether each bound is inclusive. Event triggers are run with and without inversion while the other lines toggle. This shows whether the edge is taken after polarity and only from the chosen channel. Reserved codes and invalid channels are mixed into live traffic to confirm that they block both the strobe and the match.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic [1:0] {
    TRG_OFF  = 2'd0,
    TRG_TICK = 2'd1,
    TRG_EVT  = 2'd2,
    TRG_RSV  = 2'd3
  } trg_mode_e;

  typedef enum logic [1:0] {
    CMP_LE  = 2'd0,
    CMP_GE  = 2'd1,
    CMP_WIN = 2'd2,
    CMP_RSV = 2'd3
  } cmp_rel_e;
endpackage

// File: rtl/tcc_tick_div.sv
module tcc_tick_div #(
  parameter int PRESC_W = 2,
  localparam int DIV_W  = (1 << PRESC_W) - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               restart,
  input  logic               tick,
  input  logic [PRESC_W-1:0] presc,
  output logic               fire
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;

  assign limit = (DIV_W'(1) << presc) - DIV_W'(1);
  assign fire  = en && !restart && tick && (div_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !en || restart) begin
      div_q <= '0;
    end else if (tick) begin
      div_q <= (div_q == limit) ? '0 : div_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/tcc_edge_sel.sv
module tcc_edge_sel #(
  parameter int N_CH  = 6,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CH-1:0]  lines,
  input  logic [SEL_W-1:0] sel,
  input  logic             invert,
  output logic             valid,
  output logic             lvl,
  output logic             rise
);
  logic lvl_q;

  assign valid = (sel < SEL_W'(N_CH));

  always_comb begin
    lvl = 1'b0;
    for (int i = 0; i < N_CH; i++) begin
      if (sel == SEL_W'(i)) lvl = lines[i] ^ invert;
    end
  end

  assign rise = lvl && !lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end
endmodule

// File: rtl/tcc_compare.sv
module tcc_compare
  import tcc_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int HALF = CNT_W / 2
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] top,
  input  cmp_rel_e         rel,
  output logic             hit
);
  logic [CNT_W-1:0] win_hi;
  logic [CNT_W-1:0] win_lo;

  assign win_hi = {{(CNT_W-HALF){1'b0}}, top[CNT_W-1:HALF]};
  assign win_lo = {{(CNT_W-HALF){1'b0}}, top[HALF-1:0]};

  always_comb begin
    unique case (rel)
      CMP_LE:  hit = (cnt <= top);
      CMP_GE:  hit = (cnt >= top);
      CMP_WIN: hit = (cnt <= win_hi) && (cnt >= win_lo);
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/tcc_unit.sv
module tcc_unit
  import tcc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int N_CH    = 6,
  parameter int SEL_W   = 3,
  parameter int PRESC_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   cnt_val,
  input  logic [CNT_W-1:0]   top_val,
  input  logic               tick,
  input  logic [N_CH-1:0]    evt_ch,
  input  logic [1:0]         trig_mode,
  input  logic [PRESC_W-1:0] presc_sel,
  input  logic [1:0]         cmp_sel,
  input  logic [SEL_W-1:0]   ch_sel,
  input  logic               ch_invert,
  input  logic               gate_en,
  output logic               clr_pulse,
  output logic               match_out,
  output logic               gate_out
);
  logic [1:0]         mode_q;
  logic [PRESC_W-1:0] presc_q;
  logic               cfg_chg;
  logic               cfg_ok;
  logic               tick_fire;
  logic               ch_valid;
  logic               ch_lvl;
  logic               ch_rise;
  logic               cmp_hit;
  logic               trig;
  trg_mode_e          mode_e;
  cmp_rel_e           rel_e;

  assign mode_e  = trg_mode_e'(trig_mode);
  assign rel_e   = cmp_rel_e'(cmp_sel);
  assign cfg_chg = (trig_mode != mode_q) || (presc_sel != presc_q);
  assign cfg_ok  = ((mode_e == TRG_TICK) || (mode_e == TRG_EVT && ch_valid))
                   && (rel_e != CMP_RSV);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      presc_q <= '0;
    end else begin
      mode_q  <= trig_mode;
      presc_q <= presc_sel;
    end
  end

  tcc_tick_div #(.PRESC_W(PRESC_W)) i_div (
    .clk     (clk),
    .rst     (rst),
    .en      (mode_e == TRG_TICK),
    .restart (cfg_chg),
    .tick    (tick),
    .presc   (presc_sel),
    .fire    (tick_fire)
  );

  tcc_edge_sel #(.N_CH(N_CH), .SEL_W(SEL_W)) i_edge (
    .clk    (clk),
    .rst    (rst),
    .lines  (evt_ch),
    .sel    (ch_sel),
    .invert (ch_invert),
    .valid  (ch_valid),
    .lvl    (ch_lvl),
    .rise   (ch_rise)
  );

  tcc_compare #(.CNT_W(CNT_W)) i_cmp (
    .cnt (cnt_val),
    .top (top_val),
    .rel (rel_e),
    .hit (cmp_hit)
  );

  assign trig = tick_fire || ((mode_e == TRG_EVT) && ch_rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_pulse <= 1'b0;
      match_out <= 1'b0;
      gate_out  <= 1'b0;
    end else begin
      clr_pulse <= cfg_ok && trig;
      if (!cfg_ok)   match_out <= 1'b0;
      else if (trig) match_out <= cmp_hit;
      gate_out  <= gate_en ? ch_lvl : 1'b1;
    end
  end

  // R9
  bad_mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_mode == 2'd3 || cmp_sel == 2'd3) |=> (!clr_pulse && !match_out));

  // R8
  match_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(match_out) |-> (clr_pulse || $past(!cfg_ok)));

  // R4
  evt_level_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_pulse && $past(trig_mode) == 2'd2) |-> $past(ch_lvl));

  // R3
  presc_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (presc_sel != $past(presc_sel)) |-> !tick_fire);

  // R10
  gate_open_chk: assert property (@(posedge clk) disable iff (rst)
    !gate_en |=> gate_out);
endmodule

// File: tb/test_tcc_unit.sv
module test_tcc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cnt_val = '0, top_val = '0;
  logic        tick = 1'b0;
  logic [5:0]  evt_ch = '0;
  logic [1:0]  trig_mode = '0, presc_sel = '0, cmp_sel = '0;
  logic [2:0]  ch_sel = '0;
  logic        ch_invert = 1'b0, gate_en = 1'b0;
  logic        clr_pulse, match_out, gate_out;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";
  int unsigned seed = 32'h1234_5678;

  int m_div = 0, m_pm = 0, m_pp = 0, m_lq = 0;
  int e_clr = 0, e_match = 0, e_gate = 0;

  always #2.5 clk = ~clk;

  tcc_unit i_tcc_unit (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .top_val(top_val), .tick(tick),
    .evt_ch(evt_ch), .trig_mode(trig_mode), .presc_sel(presc_sel),
    .cmp_sel(cmp_sel), .ch_sel(ch_sel), .ch_invert(ch_invert),
    .gate_en(gate_en), .clr_pulse(clr_pulse), .match_out(match_out),
    .gate_out(gate_out)
  );

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  function automatic int relation(int c, int t, int r);
    int hi, lo;
    hi = t / 256;
    lo = t % 256;
    case (r)
      0: return (c <= t) ? 1 : 0;
      1: return (c >= t) ? 1 : 0;
      2: return (c >= lo && c <= hi) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // one clock: model predicts, then outputs are compared after the edge
  task automatic cyc();
    int mode, presc, lvl, ok, chg, fire;
    mode  = int'(trig_mode);
    presc = int'(presc_sel);
    lvl   = (ch_sel < 6) ? (int'(evt_ch[ch_sel]) ^ int'(ch_invert)) : 0;
    ok    = ((mode == 1) || (mode == 2 && ch_sel < 6)) && (cmp_sel != 3);
    chg   = (mode != m_pm) || (presc != m_pp);
    fire  = 0;
    if (mode == 1) begin
      if (chg) m_div = 0;
      else if (tick) begin
        if (m_div == (1 << presc) - 1) begin fire = 1; m_div = 0; end
        else m_div++;
      end
    end else m_div = 0;
    if (mode == 2 && lvl == 1 && m_lq == 0) fire = 1;
    m_lq = lvl;
    if (!ok) begin e_clr = 0; e_match = 0; end
    else if (fire) begin e_clr = 1; e_match = relation(int'(cnt_val), int'(top_val), int'(cmp_sel)); end
    else e_clr = 0;
    e_gate = gate_en ? lvl : 1;
    m_pm = mode;
    m_pp = presc;
    @(posedge clk);
    #1;
    check("clr_pulse", int'(clr_pulse), e_clr);
    check("match_out", int'(match_out), e_match);
    check("gate_out",  int'(gate_out),  e_gate);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(posedge clk);
    #1;
    check("clr_pulse reset", int'(clr_pulse), 0);
    check("match_out reset", int'(match_out), 0);
    check("gate_out reset",  int'(gate_out),  0);
    rst = 1'b0;
    cyc();

    // R2: tick triggers at each division code, dense and sparse ticks
    cur_req = "R2";
    trig_mode = 2'd1; cmp_sel = 2'd0; top_val = 16'd100;
    for (int p = 0; p < 4; p++) begin
      presc_sel = 2'(p);
      for (int k = 0; k < 40; k++) begin
        tick = (p < 2) ? 1'b1 : ((rnd() % 3) != 0);
        cnt_val = 16'(rnd() % 200);
        cyc();
      end
    end

    // R3: change division code and mode mid-count
    cur_req = "R3";
    presc_sel = 2'd3;
    for (int k = 0; k < 60; k++) begin
      tick = 1'b1;
      if (k % 11 == 5) presc_sel = 2'(rnd() % 4);
      if (k == 30) trig_mode = 2'd0;
      if (k == 33) trig_mode = 2'd1;
      cnt_val = 16'(rnd() % 200);
      cyc();
    end

    // R5 R6 R7: relations swept across bounds, R8 hold between sparse triggers
    presc_sel = 2'd0;
    for (int r = 0; r < 3; r++) begin
      cmp_sel = 2'(r);
      cur_req = (r == 0) ? "R5" : (r == 1) ? "R6" : "R7";
      top_val = (r == 2) ? 16'h4010 : 16'd300;
      for (int k = 0; k < 60; k++) begin
        tick = 1'b1;
        if (r == 2) cnt_val = 16'(16'h000E + (k % 52));
        else        cnt_val = 16'(16'd296 + (k % 9));
        cyc();
      end
      cur_req = "R8";
      for (int k = 0; k < 30; k++) begin
        tick = ((rnd() % 4) == 0);
        cnt_val = 16'(rnd() % 600);
        cyc();
      end
    end

    // R4 R11: event edges with other lines toggling, with and without inversion
    trig_mode = 2'd2; cmp_sel = 2'd1; top_val = 16'd50;
    for (int inv = 0; inv < 2; inv++) begin
      ch_invert = 1'(inv);
      for (int c = 0; c < 6; c++) begin
        ch_sel = 3'(c);
        cur_req = "R4";
        for (int k = 0; k < 16; k++) begin
          evt_ch[c] = 1'(rnd() % 2);
          cnt_val = 16'(rnd() % 100);
          cyc();
        end
        cur_req = "R11";
        for (int k = 0; k < 12; k++) begin
          evt_ch = (6'(rnd()) & ~(6'd1 << c)) | (evt_ch & (6'd1 << c));
          cnt_val = 16'(rnd() % 100);
          cyc();
        end
      end
    end

    // R9: reserved or invalid settings mixed into live traffic
    cur_req = "R9";
    ch_invert = 1'b0;
    for (int k = 0; k < 80; k++) begin
      case (k % 4)
        0: begin trig_mode = 2'd3; cmp_sel = 2'd0; ch_sel = 3'd1; end
        1: begin trig_mode = 2'd1; cmp_sel = 2'd3; ch_sel = 3'd1; end
        2: begin trig_mode = 2'd2; cmp_sel = 2'd0; ch_sel = 3'(6 + (k / 4) % 2); end
        default: begin trig_mode = 2'd0; cmp_sel = 2'd0; ch_sel = 3'd2; end
      endcase
      evt_ch = 6'(rnd());
      tick = 1'b1;
      cnt_val = 16'(rnd() % 10);
      cyc();
      trig_mode = 2'd1; cmp_sel = 2'd0; top_val = 16'd100;
      cyc();
    end

    // R10: gate follows chosen line, open when disabled, closed on bad channel
    cur_req = "R10";
    trig_mode = 2'd0;
    for (int k = 0; k < 60; k++) begin
      gate_en = ((k / 10) % 2) == 0;
      ch_sel = 3'(k % 8);
      ch_invert = 1'((k / 20) % 2);
      evt_ch = 6'(rnd());
      cyc();
    end

    summary();
  end
endmodule